// File: doc/BRIEF.md
# Credit-Steered Chain Node Selector

This block is one station in a daisy chain of processing nodes. Packet descriptors arrive from the upstream link and are queued in a chain input FIFO. A shared local medium takes one packet at a time from the head of that queue. A raw packet is handed to a single-slot buffer toward a local compute engine if the engine still holds credit. Any other packet, or a raw packet that finds no credit, moves into the chain output FIFO. A line driver sends the head of the output FIFO downstream whenever the line is idle.

Results returned by the engine land in a single-slot return buffer. The shared medium carries them into the output FIFO and gives them precedence over new work, although a move already under way always finishes first. Engine credit is taken when a raw packet is dispatched and given back only when its result reaches the output FIFO. This caps the work in flight at the local engine.

Every move on the local medium, and every transmission on the downstream line, occupies that resource for a time proportional to the packet length. By default the engine link is ten times faster than the chain line.

Top module: `pkt_steer_node`

## Requirements
- R1: The chain input FIFO holds IN_DEPTH (default 10) descriptors. A descriptor presented on `up_valid` while that FIFO is full is discarded, and `drop_cnt` rises by exactly one for it. `drop_cnt` does not change in any other cycle.
- R2: When the medium is idle, a result waiting in the return buffer and room in the output FIFO together win the medium, even if the input FIFO head could also move.
- R3: A raw input head (`raw`=1) is dispatched to the engine buffer when credit is non-zero and that buffer is empty. Credit drops by one and `disp_cnt` rises by one when the dispatch starts.
- R4: A raw input head that meets zero credit is moved into the output FIFO unchanged, still with `raw`=1.
- R5: A processed input head (`raw`=0) is moved into the output FIFO unchanged. Every completed move from the input FIFO to the output FIFO raises `fwd_cnt` by one.
- R6: Credit starts at CREDIT_INIT (default 1). It rises by one when a result move lands in the output FIFO, and it never exceeds CREDIT_INIT.
- R7: A medium move lasts len×MED_PER_UNIT cycles, with a length of 0 taken as 1. It is never preempted: its kind stays fixed until it completes.
- R8: The output FIFO holds OUT_DEPTH (default 10) descriptors. While it is full, no move toward it starts, and no descriptor accepted into the input FIFO is lost.
- R9: `dn_valid` pulses for one cycle at the start of each downstream transmission. Consecutive starts are exactly len×LINE_PER_UNIT cycles apart when the output FIFO has data waiting. Order is kept.
- R10: The engine-side buffers use a valid/ready handshake. `eng_tx_valid` and its fields hold until `eng_tx_ready`. `eng_rx_ready` is high exactly when the return buffer is empty.
- R11: After reset there is no activity: `dn_valid`=0, `eng_tx_valid`=0, `eng_rx_ready`=1, credit equals CREDIT_INIT and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Descriptor present from upstream |
| up_raw | input | 1 | 1 = raw data, 0 = processed |
| up_len | input | 4 | Length in units (0 treated as 1) |
| up_tag | input | 8 | Packet identifier |
| eng_tx_valid | output | 1 | Engine buffer holds a dispatched packet |
| eng_tx_ready | input | 1 | Engine accepts the packet |
| eng_tx_raw | output | 1 | Raw flag of dispatched packet |
| eng_tx_len | output | 4 | Length of dispatched packet |
| eng_tx_tag | output | 8 | Tag of dispatched packet |
| eng_rx_valid | input | 1 | Engine offers a result |
| eng_rx_ready | output | 1 | Return buffer empty |
| eng_rx_raw | input | 1 | Raw flag of result |
| eng_rx_len | input | 4 | Length of result |
| eng_rx_tag | input | 8 | Tag of result |
| dn_valid | output | 1 | Start of a downstream transmission |
| dn_raw | output | 1 | Raw flag sent downstream |
| dn_len | output | 4 | Length sent downstream |
| dn_tag | output | 8 | Tag sent downstream |
| credit | output | 4 | Current engine credit |
| drop_cnt | output | 16 | Descriptors dropped at the input |
| fwd_cnt | output | 16 | Input descriptors moved to the output FIFO |
| disp_cnt | output | 16 | Descriptors dispatched to the engine |

## Verification
The hardest case to reach is the contention moment: the medium becomes free while a returned result and a raw packet are both waiting, and credit is zero. To set it up, the bench dispatches one raw packet and lets the engine take it. It then starts a long processed packet so the medium stays busy. While that move runs, it injects the result and a second raw packet in the same cycle. If the result goes first, the credit it restores lets the second raw packet be dispatched rather than forwarded, so the downstream order and the engine port show which one won. Overflow is reached by a burst of maximum-length packets that the slow line cannot drain. The bench checks that drops and forwarded packets together account for every offered descriptor.

// File: rtl/psn_pkg.sv
package psn_pkg;

    localparam int LEN_W = 4;
    localparam int TAG_W = 8;
    localparam int DUR_W = 16;
    localparam int PKT_W = 1 + LEN_W + TAG_W;

    typedef struct packed {
        logic             raw;
        logic [LEN_W-1:0] len;
        logic [TAG_W-1:0] tag;
    } pkt_t;

    typedef enum logic [1:0] {
        MV_NONE   = 2'd0,
        MV_RESULT = 2'd1,
        MV_FWD    = 2'd2,
        MV_DISP   = 2'd3
    } mv_e;

    // Cycles a resource stays occupied for a packet of the given length.
    function automatic logic [DUR_W-1:0] xfer_cycles(input logic [LEN_W-1:0] len,
                                                    input int unsigned per_unit);
        int unsigned units;
        units = (len == '0) ? 32'd1 : 32'(len);
        return DUR_W'(units * per_unit);
    endfunction

endpackage

// File: rtl/psn_fifo.sv
module psn_fifo #(
    parameter int DEPTH = 10,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/psn_slot.sv
module psn_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    logic         occupied;
    logic [W-1:0] store;

    assign in_ready  = !occupied;
    assign out_valid = occupied;
    assign out_data  = store;

    always_ff @(posedge clk) begin
        if (rst) begin
            occupied <= 1'b0;
            store    <= '0;
        end else if (in_valid && !occupied) begin
            occupied <= 1'b1;
            store    <= in_data;
        end else if (out_ready && occupied) begin
            occupied <= 1'b0;
        end
    end
endmodule

// File: rtl/psn_medium.sv
module psn_medium
    import psn_pkg::*;
#(
    parameter int CREDIT_INIT = 1,
    parameter int CRED_W      = 4,
    parameter int PER_UNIT    = 1,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_avail,
    input  pkt_t              in_head,
    output logic              in_take,
    input  logic              res_avail,
    input  pkt_t              res_head,
    output logic              res_take,
    input  logic              out_full,
    output logic              out_put,
    output pkt_t              out_pkt,
    input  logic              eng_full,
    output logic              eng_put,
    output pkt_t              eng_pkt,
    output logic              busy,
    output mv_e               kind,
    output logic [CRED_W-1:0] credit,
    output logic [CNT_W-1:0]  fwd_cnt,
    output logic [CNT_W-1:0]  disp_cnt
);
    localparam logic [CRED_W-1:0] CRED_TOP = CRED_W'(CREDIT_INIT);

    mv_e              pick;
    pkt_t             hold;
    pkt_t             chosen;
    logic [DUR_W-1:0] remain;
    logic             done;

    // Arbitration: results first, then the input head; nothing while busy.
    always_comb begin
        pick = MV_NONE;
        if (!busy) begin
            if (res_avail && !out_full) begin
                pick = MV_RESULT;
            end else if (in_avail) begin
                if (in_head.raw && (credit != '0)) begin
                    if (!eng_full) pick = MV_DISP;
                end else if (!out_full) begin
                    pick = MV_FWD;
                end
            end
        end
    end

    assign chosen   = (pick == MV_RESULT) ? res_head : in_head;
    assign in_take  = (pick == MV_FWD) || (pick == MV_DISP);
    assign res_take = (pick == MV_RESULT);
    assign done     = busy && (remain == '0);
    assign out_put  = done && ((kind == MV_RESULT) || (kind == MV_FWD));
    assign eng_put  = done && (kind == MV_DISP);
    assign out_pkt  = hold;
    assign eng_pkt  = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            kind     <= MV_NONE;
            hold     <= '0;
            remain   <= '0;
            credit   <= CRED_TOP;
            fwd_cnt  <= '0;
            disp_cnt <= '0;
        end else if (pick != MV_NONE) begin
            busy   <= 1'b1;
            kind   <= pick;
            hold   <= chosen;
            remain <= xfer_cycles(chosen.len, PER_UNIT) - DUR_W'(1);
            if (pick == MV_DISP) begin
                credit   <= credit - CRED_W'(1);
                disp_cnt <= disp_cnt + CNT_W'(1);
            end
        end else if (done) begin
            busy <= 1'b0;
            kind <= MV_NONE;
            if ((kind == MV_RESULT) && (credit < CRED_TOP)) begin
                credit <= credit + CRED_W'(1);
            end
            if (kind == MV_FWD) begin
                fwd_cnt <= fwd_cnt + CNT_W'(1);
            end
        end else if (busy) begin
            remain <= remain - DUR_W'(1);
        end
    end
endmodule

// File: rtl/psn_line.sv
module psn_line
    import psn_pkg::*;
#(
    parameter int PER_UNIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic avail,
    input  pkt_t head,
    output logic take,
    output logic dn_valid,
    output pkt_t dn_pkt,
    output logic busy
);
    logic [DUR_W-1:0] remain;

    assign take = avail && (remain == '0);
    assign busy = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
            dn_pkt   <= '0;
            remain   <= '0;
        end else begin
            dn_valid <= take;
            if (take) begin
                dn_pkt <= head;
                remain <= xfer_cycles(head.len, PER_UNIT) - DUR_W'(1);
            end else if (remain != '0) begin
                remain <= remain - DUR_W'(1);
            end
        end
    end
endmodule

// File: rtl/pkt_steer_node.sv
module pkt_steer_node
    import psn_pkg::*;
#(
    parameter int IN_DEPTH      = 10,
    parameter int OUT_DEPTH     = 10,
    parameter int CREDIT_INIT   = 1,
    parameter int CRED_W        = 4,
    parameter int MED_PER_UNIT  = 1,
    parameter int LINE_PER_UNIT = 10,
    parameter int CNT_W         = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic              up_raw,
    input  logic [3:0]        up_len,
    input  logic [7:0]        up_tag,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    output logic              eng_tx_raw,
    output logic [3:0]        eng_tx_len,
    output logic [7:0]        eng_tx_tag,
    input  logic              eng_rx_valid,
    output logic              eng_rx_ready,
    input  logic              eng_rx_raw,
    input  logic [3:0]        eng_rx_len,
    input  logic [7:0]        eng_rx_tag,
    output logic              dn_valid,
    output logic              dn_raw,
    output logic [3:0]        dn_len,
    output logic [7:0]        dn_tag,
    output logic [CRED_W-1:0] credit,
    output logic [CNT_W-1:0]  drop_cnt,
    output logic [CNT_W-1:0]  fwd_cnt,
    output logic [CNT_W-1:0]  disp_cnt
);
    localparam int IN_LW  = $clog2(IN_DEPTH + 1);
    localparam int OUT_LW = $clog2(OUT_DEPTH + 1);

    pkt_t              up_pkt, in_head, out_head, rx_pkt, res_head;
    pkt_t              out_pkt, eng_pkt, tx_pkt, line_pkt;
    logic              in_full, in_empty, in_take;
    logic              out_full, out_empty, out_put, line_take;
    logic              res_full, res_take;
    logic              eng_put, eng_slot_free;
    logic              med_busy, line_busy;
    mv_e               med_kind;
    logic [IN_LW-1:0]  in_level;
    logic [OUT_LW-1:0] out_level;

    assign up_pkt = '{raw: up_raw, len: up_len, tag: up_tag};
    assign rx_pkt = '{raw: eng_rx_raw, len: eng_rx_len, tag: eng_rx_tag};

    // Chain input queue; arrivals finding it full are discarded and counted.
    psn_fifo #(.DEPTH(IN_DEPTH), .W(PKT_W)) u_in_q (
        .clk(clk), .rst(rst),
        .wr_en(up_valid), .wr_data(up_pkt),
        .rd_en(in_take), .rd_data(in_head),
        .full(in_full), .empty(in_empty), .level(in_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_cnt <= '0;
        end else if (up_valid && in_full) begin
            drop_cnt <= drop_cnt + CNT_W'(1);
        end
    end

    // Return buffer from the engine.
    psn_slot #(.W(PKT_W)) u_ret (
        .clk(clk), .rst(rst),
        .in_valid(eng_rx_valid), .in_data(rx_pkt), .in_ready(eng_rx_ready),
        .out_valid(res_full), .out_data(res_head), .out_ready(res_take)
    );

    // Shared local medium with credit accounting.
    psn_medium #(
        .CREDIT_INIT(CREDIT_INIT), .CRED_W(CRED_W),
        .PER_UNIT(MED_PER_UNIT), .CNT_W(CNT_W)
    ) u_med (
        .clk(clk), .rst(rst),
        .in_avail(!in_empty), .in_head(in_head), .in_take(in_take),
        .res_avail(res_full), .res_head(res_head), .res_take(res_take),
        .out_full(out_full), .out_put(out_put), .out_pkt(out_pkt),
        .eng_full(!eng_slot_free), .eng_put(eng_put), .eng_pkt(eng_pkt),
        .busy(med_busy), .kind(med_kind), .credit(credit),
        .fwd_cnt(fwd_cnt), .disp_cnt(disp_cnt)
    );

    // Buffer toward the engine.
    psn_slot #(.W(PKT_W)) u_disp (
        .clk(clk), .rst(rst),
        .in_valid(eng_put), .in_data(eng_pkt), .in_ready(eng_slot_free),
        .out_valid(eng_tx_valid), .out_data(tx_pkt), .out_ready(eng_tx_ready)
    );

    assign eng_tx_raw = tx_pkt.raw;
    assign eng_tx_len = tx_pkt.len;
    assign eng_tx_tag = tx_pkt.tag;

    // Chain output queue.
    psn_fifo #(.DEPTH(OUT_DEPTH), .W(PKT_W)) u_out_q (
        .clk(clk), .rst(rst),
        .wr_en(out_put), .wr_data(out_pkt),
        .rd_en(line_take), .rd_data(out_head),
        .full(out_full), .empty(out_empty), .level(out_level)
    );

    psn_line #(.PER_UNIT(LINE_PER_UNIT)) u_line (
        .clk(clk), .rst(rst),
        .avail(!out_empty), .head(out_head), .take(line_take),
        .dn_valid(dn_valid), .dn_pkt(line_pkt), .busy(line_busy)
    );

    assign dn_raw = line_pkt.raw;
    assign dn_len = line_pkt.len;
    assign dn_tag = line_pkt.tag;
endmodule

// File: rtl/psn_checker.sv
module psn_checker
    import psn_pkg::*;
#(
    parameter int IN_DEPTH      = 10,
    parameter int OUT_DEPTH     = 10,
    parameter int CREDIT_INIT   = 1,
    parameter int CRED_W        = 4,
    parameter int LINE_PER_UNIT = 10,
    parameter int CNT_W         = 16,
    parameter int IN_LW         = 4,
    parameter int OUT_LW        = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              in_full,
    input logic [IN_LW-1:0]  in_level,
    input logic              out_full,
    input logic [OUT_LW-1:0] out_level,
    input logic              res_full,
    input logic              med_busy,
    input mv_e               med_kind,
    input logic [CRED_W-1:0] credit,
    input logic [CNT_W-1:0]  drop_cnt,
    input logic              dn_valid,
    input logic [3:0]        dn_len,
    input logic              line_busy,
    input logic              eng_tx_valid,
    input logic              eng_tx_ready,
    input logic [7:0]        eng_tx_tag
);
    logic [DUR_W-1:0] since_start;
    logic [DUR_W-1:0] last_dur;
    logic             seen_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_start <= '0;
            last_dur    <= '0;
            seen_start  <= 1'b0;
        end else if (dn_valid) begin
            since_start <= DUR_W'(1);
            last_dur    <= xfer_cycles(dn_len, LINE_PER_UNIT);
            seen_start  <= 1'b1;
        end else if (since_start != '1) begin
            since_start <= since_start + DUR_W'(1);
        end
    end

    AST_IN_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(in_level) <= IN_DEPTH); // R1
    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (up_valid && in_full) |=> (drop_cnt == $past(drop_cnt) + CNT_W'(1))); // R1
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(up_valid && in_full) |=> $stable(drop_cnt)); // R1
    AST_RESULT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!med_busy && res_full && !out_full) |=> (med_busy && med_kind == MV_RESULT)); // R2
    AST_CREDIT_TAKE: assert property (@(posedge clk) disable iff (rst)
        ($rose(med_busy) && med_kind == MV_DISP) |-> (credit == $past(credit) - CRED_W'(1))); // R3
    AST_CREDIT_MAX: assert property (@(posedge clk) disable iff (rst)
        32'(credit) <= CREDIT_INIT); // R6
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (med_busy && $past(med_busy)) |-> $stable(med_kind)); // R7
    AST_OUT_STALL: assert property (@(posedge clk) disable iff (rst)
        (!med_busy && out_full) |=> !(med_busy && (med_kind == MV_FWD || med_kind == MV_RESULT))); // R8
    AST_OUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(out_level) <= OUT_DEPTH); // R8
    AST_LINE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && seen_start) |-> (since_start >= last_dur)); // R9
    AST_LINE_IDLE_START: assert property (@(posedge clk) disable iff (rst)
        line_busy |=> !dn_valid); // R9
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_valid && !eng_tx_ready) |=> (eng_tx_valid && $stable(eng_tx_tag))); // R10
endmodule

bind pkt_steer_node psn_checker #(
    .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .CREDIT_INIT(CREDIT_INIT),
    .CRED_W(CRED_W), .LINE_PER_UNIT(LINE_PER_UNIT), .CNT_W(CNT_W),
    .IN_LW(IN_LW), .OUT_LW(OUT_LW)
) u_psn_checker (
    .clk(clk), .rst(rst), .up_valid(up_valid), .in_full(in_full),
    .in_level(in_level), .out_full(out_full), .out_level(out_level),
    .res_full(res_full), .med_busy(med_busy), .med_kind(med_kind),
    .credit(credit), .drop_cnt(drop_cnt), .dn_valid(dn_valid),
    .dn_len(dn_len), .line_busy(line_busy), .eng_tx_valid(eng_tx_valid),
    .eng_tx_ready(eng_tx_ready), .eng_tx_tag(eng_tx_tag)
);

// File: tb/pkt_steer_node_bench.sv
module pkt_steer_node_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_PU    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0, up_raw = 1'b0;
    logic [3:0]  up_len = '0;
    logic [7:0]  up_tag = '0;
    logic        eng_tx_valid, eng_tx_ready = 1'b0, eng_tx_raw;
    logic [3:0]  eng_tx_len;
    logic [7:0]  eng_tx_tag;
    logic        eng_rx_valid = 1'b0, eng_rx_ready, eng_rx_raw = 1'b0;
    logic [3:0]  eng_rx_len = '0;
    logic [7:0]  eng_rx_tag = '0;
    logic        dn_valid, dn_raw;
    logic [3:0]  dn_len;
    logic [7:0]  dn_tag;
    logic [3:0]  credit;
    logic [15:0] drop_cnt, fwd_cnt, disp_cnt;

    int n_cmp = 0, n_bad = 0, cyc = 0, dn_n = 0;
    bit finished = 0;
    int rec_tag [256];
    int rec_raw [256];
    int rec_len [256];
    int rec_cyc [256];

    pkt_steer_node u_pkt_steer_node (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_raw(up_raw), .up_len(up_len), .up_tag(up_tag),
        .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
        .eng_tx_raw(eng_tx_raw), .eng_tx_len(eng_tx_len), .eng_tx_tag(eng_tx_tag),
        .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
        .eng_rx_raw(eng_rx_raw), .eng_rx_len(eng_rx_len), .eng_rx_tag(eng_rx_tag),
        .dn_valid(dn_valid), .dn_raw(dn_raw), .dn_len(dn_len), .dn_tag(dn_tag),
        .credit(credit), .drop_cnt(drop_cnt), .fwd_cnt(fwd_cnt), .disp_cnt(disp_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && dn_valid && dn_n < 256) begin
            rec_tag[dn_n] = int'(dn_tag);
            rec_raw[dn_n] = int'(dn_raw);
            rec_len[dn_n] = int'(dn_len);
            rec_cyc[dn_n] = cyc;
            dn_n = dn_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input bit raw, input int len, input int tag);
        up_raw = raw; up_len = 4'(len); up_tag = 8'(tag); up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_dn(input int target);
        int t = 0;
        while (dn_n < target && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic wait_tx();
        int t = 0;
        while (!eng_tx_valid && t < 500) begin @(negedge clk); t++; end
    endtask

    task automatic take_tx();
        eng_tx_ready = 1'b1;
        @(negedge clk);
        eng_tx_ready = 1'b0;
    endtask

    task automatic give_result(input int len, input int tag);
        eng_rx_raw = 1'b0; eng_rx_len = 4'(len); eng_rx_tag = 8'(tag); eng_rx_valid = 1'b1;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base, d0, f0, out_n, drops, mono;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11", "dn_valid", dn_valid, 0);
        chk("R11", "eng_tx_valid", eng_tx_valid, 0);
        chk("R11", "eng_rx_ready", eng_rx_ready, 1);
        chk("R11", "credit", credit, 1);
        chk("R11", "counters", drop_cnt + fwd_cnt + disp_cnt, 0);

        // R5 R7 R9: processed pairs, pass-through and line spacing sweep
        for (int len = 1; len <= 4; len++) begin
            base = dn_n;
            f0 = int'(fwd_cnt);
            send(0, len, 16 * len);
            send(0, len, 16 * len + 1);
            wait_dn(base + 2);
            chk("R5", "first tag", rec_tag[base], 16 * len);
            chk("R5", "second tag", rec_tag[base + 1], 16 * len + 1);
            chk("R5", "raw flag kept", rec_raw[base], 0);
            chk("R5", "length kept", rec_len[base + 1], len);
            chk("R9", "start spacing", rec_cyc[base + 1] - rec_cyc[base], len * LINE_PU);
            chk("R5", "fwd count", int'(fwd_cnt) - f0, 2);
            idle(len * LINE_PU + 5);
        end

        // R3 R4 R10 R6: dispatch with credit, forward without it, credit return
        base = dn_n;
        send(1, 2, 8'h30);
        wait_tx();
        chk("R3", "dispatched tag", eng_tx_tag, 8'h30);
        chk("R3", "dispatched raw flag", eng_tx_raw, 1);
        chk("R3", "credit after dispatch", credit, 0);
        chk("R3", "disp count", disp_cnt, 1);
        send(1, 1, 8'h31);
        wait_dn(base + 1);
        chk("R4", "no-credit raw forwarded tag", rec_tag[base], 8'h31);
        chk("R4", "no-credit raw flag", rec_raw[base], 1);
        chk("R4", "disp count unchanged", disp_cnt, 1);
        idle(2);
        chk("R10", "tx held without ready", eng_tx_valid, 1);
        take_tx();
        chk("R10", "tx released", eng_tx_valid, 0);
        chk("R10", "rx ready when empty", eng_rx_ready, 1);
        give_result(1, 8'h30);
        chk("R10", "rx ready drops when slot full", eng_rx_ready, 0);
        wait_dn(base + 2);
        chk("R6", "result tag downstream", rec_tag[base + 1], 8'h30);
        chk("R6", "credit restored", credit, 1);
        idle(30);

        // R2 R7: result and raw packet contend; result must go first
        base = dn_n;
        send(1, 2, 8'h40);
        wait_tx();
        take_tx();
        send(0, 15, 8'h41);
        idle(3);
        eng_rx_raw = 1'b0; eng_rx_len = 4'd1; eng_rx_tag = 8'h40; eng_rx_valid = 1'b1;
        up_raw = 1'b1; up_len = 4'd2; up_tag = 8'h42; up_valid = 1'b1;
        @(negedge clk);
        eng_rx_valid = 1'b0; up_valid = 1'b0;
        wait_tx();
        chk("R2", "raw after result is dispatched", eng_tx_tag, 8'h42);
        chk("R2", "disp count", disp_cnt, 3);
        wait_dn(base + 2);
        chk("R7", "running move finishes first", rec_tag[base], 8'h41);
        chk("R2", "result second", rec_tag[base + 1], 8'h40);
        chk("R3", "credit taken again", credit, 0);
        take_tx();
        give_result(1, 8'h42);
        wait_dn(base + 3);
        chk("R6", "credit back to init", credit, 1);
        chk("R6", "last result tag", rec_tag[base + 2], 8'h42);
        idle(30);

        // R1 R8: overflow burst of 40 long processed packets
        base = dn_n;
        d0 = int'(drop_cnt);
        f0 = int'(fwd_cnt);
        for (int k = 0; k < 40; k++) send(0, 15, k);
        idle(2600);
        out_n = dn_n - base;
        drops = int'(drop_cnt) - d0;
        chk("R1", "drops plus delivered", drops + out_n, 40);
        chk("R1", "drops within bound", (drops >= 27 && drops <= 30) ? 1 : 0, 1);
        chk("R8", "delivered fills both queues", (out_n >= 10) ? 1 : 0, 1);
        chk("R5", "fwd count in burst", int'(fwd_cnt) - f0, out_n);
        mono = 1;
        for (int i = 1; i < out_n; i++) if (rec_tag[base + i] <= rec_tag[base + i - 1]) mono = 0;
        chk("R9", "order kept in burst", mono, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule